// File: doc/BRIEF.md
# Duty-Modulated Current Sample Decoder

This block sits on the controller side of an isolated phase-current sensor that reports its measurement as an active-low, duty-modulated pulse train. The sensor is clocked by a synchronisation square wave from the controller. Each half-period of that wave is one measurement cycle. Cycles in which the sync line is high belong to channel 1, and cycles in which it is low belong to channel 2. The decoder counts system clocks to find the length of each cycle and the time the pulse line is released within it. It pairs the release time of one cycle with the length of the cycle before it, divides the two into a fixed-point duty ratio, and maps that ratio linearly onto a signed input-voltage code in microvolts. It then subtracts the offset value that belongs to the channel and presents the result with a one-clock valid strobe.

Both inputs are expected to be synchronised to the system clock already. Because each cycle is measured against its own length, a sync wave whose high and low halves differ is handled without extra correction. An optional mode replaces each sample with the mean of it and the sample before it. Under centre-aligned PWM this cancels the ripple that alternates from one half-period to the next. Ratios far outside the sensor's useful span, and cycles too long for the counters, are flagged and produce no sample.

Top module: `duty_current_decoder`

## Requirements
- R1: While reset is asserted and after its release, `valid_o`, `chan_o` and `range_err_o` are 0 and `sample_o` is 0 until the first sample is produced.
- R2: A cycle is the run of consecutive clock edges at which `sync_i` holds one level. A sample is tagged with the level of the earlier cycle of its pair: `chan_o`=1 for a high (channel 1) cycle and `chan_o`=0 for a low (channel 2) cycle. The two levels may last different numbers of clocks.
- R3: Let H(n+1) be the number of clock edges in cycle n+1 at which `pwm_i` is 1, and let L(n) be the number of edges in cycle n. The ratio of sample n is q = floor(H(n+1)·65536 / L(n)).
- R4: Before any offset is applied, the code is v = floor((131072 − 10·q)·250000 / 65536) µV. A 20 % ratio gives 0 µV, 10 % gives +250000 and 30 % gives −250000.
- R5: Before the offset is subtracted, v is clamped to the range −250000 to +250000.
- R6: The output is the clamped code minus `ofs_ch1_i` for channel 1 samples, or minus `ofs_ch2_i` for channel 2 samples. Both offsets are signed µV.
- R7: With `avg_en_i`=1, each good sample is output as floor((s + s_prev)/2), where s_prev is the previous good sample, kept in either mode. A good sample with no previous good sample yields no output.
- R8: If 20·q < 65536 or 20·q > 458752 (a ratio below 5 % or above 35 %), the sample yields no strobe, clears the averaging history and sets `range_err_o`. That flag stays set until reset.
- R9: A cycle longer than 4095 clocks (counter overflow) invalidates both samples that use it, with the same effect as R8.
- R10: Counting starts at the first sync edge after reset. The first complete cycle produces no sample. Every later completed cycle produces at most one sample, and `valid_o` is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_i | input | 1 | Synchronised sync wave; its level selects the channel |
| pwm_i | input | 1 | Synchronised active-low pulse line from the sensor |
| avg_en_i | input | 1 | 1 selects two-sample averaging |
| ofs_ch1_i | input | 16 | Signed offset in µV for channel 1 |
| ofs_ch2_i | input | 16 | Signed offset in µV for channel 2 |
| valid_o | output | 1 | One-clock strobe for a new sample |
| chan_o | output | 1 | Channel of the sample: 1 = sync high, 0 = sync low |
| sample_o | output | 20 | Signed corrected input voltage in µV |
| range_err_o | output | 1 | Sticky flag for an out-of-range ratio or counter overflow |

## Verification
The pulse stream is swept with release times spread over the whole sensor span. This is done first with equal half-periods and zero offsets, which isolates the linear map. It is then repeated with unequal half-periods and distinct offsets per channel, which separates the shifted pairing and the per-channel subtraction from the map itself. Ratios in the clamping bands near both ends expose the saturation limits. Ratios beyond those bands, and one half-period longer than the counter, show that such samples are suppressed and the flag is held. A run with averaging enabled, whose history carries over from the previous pattern, checks the two-sample mean and its rounding toward minus infinity.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

    // Channel tag carried with each measurement cycle: level of sync during it.
    typedef enum logic {
        DCD_CH_LOW  = 1'b0,
        DCD_CH_HIGH = 1'b1
    } dcd_chan_e;

    // Ratio window bounds expressed as multiples of 1/20 of full scale.
    localparam int unsigned DCD_WIN_LO_TWENTIETHS = 1;  // 5 %
    localparam int unsigned DCD_WIN_HI_TWENTIETHS = 7;  // 35 %

endpackage

// File: rtl/dcd_cycle_timer.sv
module dcd_cycle_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_i,
    input  logic             pwm_i,
    output logic             done_o,
    output logic [CNT_W-1:0] len_o,
    output logic [CNT_W-1:0] hi_o,
    output dcd_pkg::dcd_chan_e lvl_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             sync_prev;
        logic             armed;
        logic [CNT_W-1:0] len_cnt;
        logic [CNT_W-1:0] hi_cnt;
        logic             ovf;
        logic             done;
        logic [CNT_W-1:0] len_out;
        logic [CNT_W-1:0] hi_out;
        logic             lvl_out;
        logic             ovf_out;
    } timer_st_t;

    timer_st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.sync_prev = sync_i;
        if (sync_i != st_q.sync_prev) begin
            // Edge: close the running cycle, this clock opens the next one.
            st_d.done    = st_q.armed;
            st_d.len_out = st_q.len_cnt;
            st_d.hi_out  = st_q.hi_cnt;
            st_d.lvl_out = st_q.sync_prev;
            st_d.ovf_out = st_q.ovf;
            st_d.armed   = 1'b1;
            st_d.len_cnt = CNT_ONE;
            st_d.hi_cnt  = pwm_i ? CNT_ONE : '0;
            st_d.ovf     = 1'b0;
        end else begin
            if (st_q.len_cnt == CNT_MAX) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.len_cnt = st_q.len_cnt + CNT_ONE;
            end
            if (pwm_i) begin
                if (st_q.hi_cnt == CNT_MAX) begin
                    st_d.ovf = 1'b1;
                end else begin
                    st_d.hi_cnt = st_q.hi_cnt + CNT_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign len_o  = st_q.len_out;
    assign hi_o   = st_q.hi_out;
    assign lvl_o  = dcd_pkg::dcd_chan_e'(st_q.lvl_out);
    assign ovf_o  = st_q.ovf_out;

endmodule

// File: rtl/dcd_divider.sv
module dcd_divider #(
    parameter int NUM_W = 28,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int STEP_W = $clog2(NUM_W + 1);
    localparam logic [STEP_W-1:0] STEP_ONE  = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_LOAD = STEP_W'(NUM_W);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [STEP_W-1:0] step;
        logic [DEN_W-1:0]  rem;
        logic [NUM_W-1:0]  dvd;
        logic [DEN_W-1:0]  den;
    } div_st_t;

    div_st_t          st_d, st_q;
    logic [DEN_W:0]   trial;
    logic             qbit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        trial     = {st_q.rem, st_q.dvd[NUM_W-1]};
        qbit      = 1'b0;
        if (start_i) begin
            st_d.busy = 1'b1;
            st_d.step = STEP_LOAD;
            st_d.rem  = '0;
            st_d.dvd  = num_i;
            st_d.den  = den_i;
        end else if (st_q.busy) begin
            // One restoring step: shift in the next dividend bit, subtract if it fits.
            if (trial >= {1'b0, st_q.den}) begin
                trial = trial - {1'b0, st_q.den};
                qbit  = 1'b1;
            end
            st_d.rem  = trial[DEN_W-1:0];
            st_d.dvd  = {st_q.dvd[NUM_W-2:0], qbit};
            st_d.step = st_q.step - STEP_ONE;
            if (st_q.step == STEP_ONE) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign quo_o  = st_q.dvd;

endmodule

// File: rtl/dcd_sample_map.sv
module dcd_sample_map #(
    parameter int CNT_W   = 12,
    parameter int FRAC_W  = 16,
    parameter int SMP_W   = 20,
    parameter int OFS_W   = 16,
    parameter int FULL_UV = 250000
) (
    input  logic [CNT_W+FRAC_W-1:0]  quo_i,
    input  logic signed [OFS_W-1:0]  ofs_i,
    output logic signed [SMP_W-1:0]  smp_o,
    output logic                     bad_o
);
    localparam int QW = CNT_W + FRAC_W;
    localparam logic signed [63:0] ONE_FX   = 64'sd1 <<< FRAC_W;
    localparam logic signed [63:0] ZERO_PT  = 64'sd2 * ONE_FX;   // 20 % times ten
    localparam logic signed [63:0] FULL_S   = 64'(FULL_UV);
    localparam logic signed [63:0] WIN_LO   = 64'(dcd_pkg::DCD_WIN_LO_TWENTIETHS) * ONE_FX;
    localparam logic signed [63:0] WIN_HI   = 64'(dcd_pkg::DCD_WIN_HI_TWENTIETHS) * ONE_FX;

    logic signed [63:0] q_s;
    logic signed [63:0] scaled;
    logic signed [63:0] vin;
    logic signed [SMP_W-1:0] vin_sat;
    logic signed [SMP_W-1:0] ofs_ext;

    always_comb begin
        q_s    = $signed({{(64-QW){1'b0}}, quo_i});
        bad_o  = ((q_s * 64'sd20) < WIN_LO) || ((q_s * 64'sd20) > WIN_HI);
        scaled = (ZERO_PT - 64'sd10 * q_s) * FULL_S;
        vin    = scaled >>> FRAC_W;
        if (vin > FULL_S) begin
            vin_sat = SMP_W'(FULL_UV);
        end else if (vin < -FULL_S) begin
            vin_sat = -SMP_W'(FULL_UV);
        end else begin
            vin_sat = vin[SMP_W-1:0];
        end
        ofs_ext = {{(SMP_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i};
        smp_o   = vin_sat - ofs_ext;
    end

endmodule

// File: rtl/duty_current_decoder.sv
module duty_current_decoder #(
    parameter int CNT_W   = 12,
    parameter int FRAC_W  = 16,
    parameter int SMP_W   = 20,
    parameter int OFS_W   = 16,
    parameter int FULL_UV = 250000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_i,
    input  logic                     pwm_i,
    input  logic                     avg_en_i,
    input  logic signed [OFS_W-1:0]  ofs_ch1_i,
    input  logic signed [OFS_W-1:0]  ofs_ch2_i,
    output logic                     valid_o,
    output logic                     chan_o,
    output logic signed [SMP_W-1:0]  sample_o,
    output logic                     range_err_o
);
    localparam int QW = CNT_W + FRAC_W;

    typedef struct packed {
        logic                    have_prev;
        logic [CNT_W-1:0]        prev_len;
        logic                    prev_lvl;
        logic                    prev_ovf;
        logic                    pend_lvl;
        logic                    pend_err;
        logic                    hist_have;
        logic signed [SMP_W-1:0] hist_val;
        logic                    valid;
        logic                    chan;
        logic signed [SMP_W-1:0] sample;
        logic                    err;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                    cyc_done;
    logic [CNT_W-1:0]        cyc_len;
    logic [CNT_W-1:0]        cyc_hi;
    dcd_pkg::dcd_chan_e      cyc_lvl;
    logic                    cyc_ovf;
    logic                    div_start;
    logic [QW-1:0]           div_num;
    logic                    div_done;
    logic [QW-1:0]           div_quo;
    logic signed [OFS_W-1:0] ofs_sel;
    logic signed [SMP_W-1:0] map_smp;
    logic                    map_bad;
    logic signed [SMP_W:0]   avg_sum;

    dcd_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .pwm_i  (pwm_i),
        .done_o (cyc_done),
        .len_o  (cyc_len),
        .hi_o   (cyc_hi),
        .lvl_o  (cyc_lvl),
        .ovf_o  (cyc_ovf)
    );

    assign div_start = cyc_done && st_q.have_prev;
    assign div_num   = {cyc_hi, {FRAC_W{1'b0}}};

    dcd_divider #(.NUM_W(QW), .DEN_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (div_num),
        .den_i   (st_q.prev_len),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    assign ofs_sel = (st_q.pend_lvl == dcd_pkg::DCD_CH_HIGH) ? ofs_ch1_i : ofs_ch2_i;

    dcd_sample_map #(
        .CNT_W   (CNT_W),
        .FRAC_W  (FRAC_W),
        .SMP_W   (SMP_W),
        .OFS_W   (OFS_W),
        .FULL_UV (FULL_UV)
    ) u_map (
        .quo_i (div_quo),
        .ofs_i (ofs_sel),
        .smp_o (map_smp),
        .bad_o (map_bad)
    );

    assign avg_sum = {map_smp[SMP_W-1], map_smp} + {st_q.hist_val[SMP_W-1], st_q.hist_val};

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (cyc_done) begin
            // Pair the release time of this cycle with the length of the one before.
            if (st_q.have_prev) begin
                st_d.pend_lvl = st_q.prev_lvl;
                st_d.pend_err = cyc_ovf || st_q.prev_ovf;
            end
            st_d.have_prev = 1'b1;
            st_d.prev_len  = cyc_len;
            st_d.prev_lvl  = cyc_lvl;
            st_d.prev_ovf  = cyc_ovf;
        end
        if (div_done) begin
            if (map_bad || st_q.pend_err) begin
                st_d.err       = 1'b1;
                st_d.hist_have = 1'b0;
            end else begin
                st_d.hist_have = 1'b1;
                st_d.hist_val  = map_smp;
                st_d.chan      = st_q.pend_lvl;
                if (!avg_en_i) begin
                    st_d.valid  = 1'b1;
                    st_d.sample = map_smp;
                end else if (st_q.hist_have) begin
                    st_d.valid  = 1'b1;
                    st_d.sample = avg_sum[SMP_W:1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o     = st_q.valid;
    assign chan_o      = st_q.chan;
    assign sample_o    = st_q.sample;
    assign range_err_o = st_q.err;

endmodule

// File: rtl/dcd_checker.sv
module dcd_checker #(
    parameter int SMP_W   = 20,
    parameter int OFS_W   = 16,
    parameter int FULL_UV = 250000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    valid_o,
    input logic                    chan_o,
    input logic signed [SMP_W-1:0] sample_o,
    input logic                    range_err_o
);
    localparam int LIM = FULL_UV + (1 << (OFS_W - 1));

    // R10: the strobe never lasts two clocks
    p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R8: the error flag holds until reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |=> range_err_o);

    // R8: the sample that raises the flag produces no strobe
    p_err_suppress_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(range_err_o) |-> !valid_o);

    // R5: a strobed code stays inside the clamp widened by the largest offset
    p_sample_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sample_o <= LIM && sample_o >= -LIM));

    // R2: a strobed sample carries a known channel tag
    p_chan_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !$isunknown(chan_o));

endmodule

bind duty_current_decoder dcd_checker #(
    .SMP_W   (SMP_W),
    .OFS_W   (OFS_W),
    .FULL_UV (FULL_UV)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_o     (valid_o),
    .chan_o      (chan_o),
    .sample_o    (sample_o),
    .range_err_o (range_err_o)
);

// File: tb/duty_current_decoder_tb.sv
module duty_current_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_MAX    = 4095;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_i = 1'b0;
    logic pwm_i = 1'b0;
    logic avg_en = 1'b0;
    logic signed [15:0] ofs1 = '0;
    logic signed [15:0] ofs2 = '0;
    logic valid;
    logic chan;
    logic signed [19:0] sample;
    logic range_err;

    duty_current_decoder u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_i      (sync_i),
        .pwm_i       (pwm_i),
        .avg_en_i    (avg_en),
        .ofs_ch1_i   (ofs1),
        .ofs_ch2_i   (ofs2),
        .valid_o     (valid),
        .chan_o      (chan),
        .sample_o    (sample),
        .range_err_o (range_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    longint exp_val[$];
    int     exp_ch[$];
    string  exp_req[$];
    string  cur_req = "R4";

    // Reference model state
    int c_len, c_hi, c_lvl;
    bit c_valid;
    int p_len, p_lvl;
    bit p_ovf, p_have;
    bit h_have;
    longint h_val;
    int next_lvl = 1;
    int last_len = 50;
    bit last_valid = 1'b0;

    task automatic check(bit ok, string req, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic model_sample(int hi, int plen, int plvl, bit ovf);
        longint q, vin, s;
        q = (longint'(hi) * 65536) / plen;
        if (ovf || q * 20 < 65536 || q * 20 > 458752) begin
            h_have = 1'b0;
            return;
        end
        vin = ((131072 - 10 * q) * 250000) >>> 16;
        if (vin > 250000) vin = 250000;
        if (vin < -250000) vin = -250000;
        s = vin - ((plvl == 1) ? longint'(ofs1) : longint'(ofs2));
        if (!avg_en) begin
            exp_val.push_back(s); exp_ch.push_back(plvl); exp_req.push_back(cur_req);
        end else if (h_have) begin
            exp_val.push_back((s + h_val) >>> 1); exp_ch.push_back(plvl); exp_req.push_back(cur_req);
        end
        h_have = 1'b1;
        h_val  = s;
    endtask

    task automatic complete_cycle();
        bit ovf;
        if (c_valid) begin
            ovf = (c_len > CNT_MAX);
            if (p_have) model_sample(c_hi, p_len, p_lvl, ovf || p_ovf);
            p_len  = c_len;
            p_lvl  = c_lvl;
            p_ovf  = ovf;
            p_have = 1'b1;
        end
    endtask

    task automatic drive_cycle(int lvl, int len, int hi);
        complete_cycle();
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            sync_i = (lvl == 1);
            pwm_i  = (i < hi);
        end
        c_len = len; c_hi = hi; c_lvl = lvl; c_valid = 1'b1;
        last_len = len;
        next_lvl = 1 - lvl;
    endtask

    // n cycles with ratios spread over [lo, lo+span] percent, then a long closing cycle
    task automatic run_seq(int n, int lo, int span, int len_hi, int len_lo);
        for (int k = 0; k < n; k++) begin
            int pct, len;
            pct = lo + (k * 7) % (span + 1);
            len = (next_lvl == 1) ? len_hi : len_lo;
            drive_cycle(next_lvl, len, (last_len * pct) / 100);
        end
        drive_cycle(next_lvl, 120, (last_len * 20) / 100);
        // R10: every expected sample appeared, none extra
        check(exp_val.size() == 0, "R10", exp_val.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sync_i = 1'b0; pwm_i = 1'b0;
        repeat (3) @(negedge clk);
        c_valid = 1'b0; p_have = 1'b0; h_have = 1'b0;
        exp_val.delete(); exp_ch.delete(); exp_req.delete();
        next_lvl = 1; last_len = 50;
        // R1: outputs idle during reset
        check(valid == 1'b0 && range_err == 1'b0, "R1", {valid, range_err}, 0);
        check(sample == 0 && chan == 1'b0, "R1", sample, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(valid == 1'b0 && range_err == 1'b0 && sample == 0, "R1", sample, 0);
    endtask

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (valid) begin
                if (last_valid) check(1'b0, "R10", 1, 0);
                if (exp_val.size() == 0) begin
                    check(1'b0, "R10", sample, 0);
                end else begin
                    longint ev; int ec; string er;
                    ev = exp_val.pop_front();
                    ec = exp_ch.pop_front();
                    er = exp_req.pop_front();
                    check(longint'(sample) == ev, er, sample, ev);
                    check(int'(chan) == ec, "R2", chan, ec);
                end
            end
            last_valid = valid;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R4: equal half-periods, no offsets: pure linear map
        cur_req = "R4";
        run_seq(12, 10, 20, 50, 50);

        // R3: strongly unequal half-periods, shifted pairing
        cur_req = "R3";
        run_seq(14, 10, 20, 90, 40);

        // R6: distinct per-channel offsets
        ofs1 = 16'sd1000; ofs2 = -16'sd1500;
        cur_req = "R6";
        run_seq(16, 10, 20, 60, 44);

        // R5: clamping bands at both ends
        cur_req = "R5";
        run_seq(8, 6, 3, 200, 160);
        run_seq(8, 31, 3, 200, 160);

        // R7: two-sample mean, history carried from the previous pattern
        avg_en = 1'b1;
        cur_req = "R7";
        run_seq(12, 10, 20, 80, 70);
        check(range_err == 1'b0, "R8", range_err, 0);

        // R8: ratios outside the window
        avg_en = 1'b0;
        cur_req = "R8";
        run_seq(10, 1, 45, 100, 100);
        check(range_err == 1'b1, "R8", range_err, 1);

        // R9: one half-period longer than the counter
        do_reset();
        ofs1 = '0; ofs2 = '0;
        cur_req = "R9";
        drive_cycle(1, 60, 12);
        drive_cycle(0, 60, 12);
        drive_cycle(1, 60, 12);
        check(range_err == 1'b0, "R9", range_err, 0);
        drive_cycle(0, 4200, 12);
        drive_cycle(1, 60, 840);
        drive_cycle(0, 60, 12);
        drive_cycle(1, 120, 12);
        check(exp_val.size() == 0, "R9", exp_val.size(), 0);
        check(range_err == 1'b1, "R9", range_err, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule